// File: doc/BRIEF.md
# UART Receive Character Gate

This block sits between a UART character deframer and the receive FIFO and decides, for every completed character, whether it is stored, whether it is a flow-control character (XON or XOFF) and whether it matches the programmed special character. Software sets a receiver-disable request. The block brings that request into effect only at a character boundary, so a character that is already arriving is always handled under the setting that was in force when it began.

While the receiver is disabled, the deframer keeps running so that it stays in step with the line. Characters reach this block as usual. Data characters are dropped and special-character matching is suppressed, but XON and XOFF are still recognised and reported, so flow control keeps working. A configuration bit chooses whether recognised flow-control characters are also written to the FIFO while the receiver is enabled. All decisions are combinational on the character-valid strobe, so every output pulse lines up with that strobe.

Top module: `uart_rx_gate`

## Requirements
- R1: After reset, `rx_disabled` is 0 and `fifo_wr`, `xon_hit`, `xoff_hit` and `special_hit` are 0.
- R2: When `char_valid` is high, `rx_disabled` is 0, and the byte equals neither `xon_char` nor `xoff_char`, `fifo_wr` is high in the same cycle and `fifo_data` equals `char_data`.
- R3: When `char_valid` is high and `rx_disabled` is 1, `fifo_wr` stays low for every byte value.
- R4: While no character is in progress, `rx_disabled` takes the value of `disable_req` on the next clock edge.
- R5: A character is in progress from the cycle after `rx_start` is high up to and including the cycle where `char_valid` is high. During that span `rx_disabled` does not change. The character that ends the span is gated by the old value, and `rx_disabled` takes `disable_req` on the edge that ends the span.
- R6: `xon_hit` (or `xoff_hit`) is high exactly when `char_valid` is high and `char_data` equals `xon_char` (or `xoff_char`), whatever the value of `rx_disabled`.
- R7: `special_hit` is high exactly when `char_valid` is high, `rx_disabled` is 0, `char_data` equals `special_char`, and the byte is not a flow-control character.
- R8: A flow-control byte is written to the FIFO only if `store_flow` is 1 and `rx_disabled` is 0. When `store_flow` is 0, it is never written.
- R9: When `char_valid` is low, `fifo_wr`, `xon_hit`, `xoff_hit` and `special_hit` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disable_req | input | 1 | Requested receiver-disable setting |
| store_flow | input | 1 | 1: also write XON/XOFF bytes to the FIFO while enabled |
| xon_char | input | DATA_W | XON byte value |
| xoff_char | input | DATA_W | XOFF byte value |
| special_char | input | DATA_W | Special byte value |
| rx_start | input | 1 | Start bit seen by the deframer |
| char_valid | input | 1 | Completed character strobe |
| char_data | input | DATA_W | Received character |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_data | output | DATA_W | Data to the receive FIFO |
| xon_hit | output | 1 | XON received pulse |
| xoff_hit | output | 1 | XOFF received pulse |
| special_hit | output | 1 | Special character received pulse |
| rx_disabled | output | 1 | Disable setting currently in effect |

## Verification
Every one of the 256 byte values is sent under all four combinations of effective disable and `store_flow`. This separates plain data, XON, XOFF and the special byte, and shows that special matching and data writes depend on the disable state while flow detection does not. The sweep is then repeated with a second set of character values, one that places the special byte on a flow-control code, which exposes a wrong precedence between special and flow matching. Separate sequences change `disable_req` in the middle of a character, in both directions, and while the receiver is idle. These show whether the change is deferred to the character boundary and whether the finishing character is gated by the old setting.

// File: rtl/uart_rx_gate_pkg.sv
package uart_rx_gate_pkg;

  typedef struct packed {
    logic is_xon;
    logic is_xoff;
    logic is_special;
  } char_class_t;

  // Decide what the byte is. A flow code wins over the special match.
  function automatic char_class_t classify_char(
    input logic [7:0] data,
    input logic [7:0] xon,
    input logic [7:0] xoff,
    input logic [7:0] spec
  );
    char_class_t c;
    c.is_xon     = (data == xon);
    c.is_xoff    = (data == xoff);
    c.is_special = (data == spec) && !c.is_xon && !c.is_xoff;
    return c;
  endfunction

  // Store decision for a completed character.
  function automatic logic store_decision(
    input logic         disabled,
    input logic         keep_flow,
    input char_class_t  c
  );
    logic flow;
    flow = c.is_xon || c.is_xoff;
    return !disabled && (!flow || keep_flow);
  endfunction

endpackage

// File: rtl/rx_activity_track.sv
module rx_activity_track (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_start,
  input  logic char_valid,
  output logic busy
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          busy_q <= 1'b0;
    else if (rx_start)   busy_q <= 1'b1;
    else if (char_valid) busy_q <= 1'b0;
  end

  assign busy = busy_q;

  assert_start_sets_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start |=> busy);
  assert_end_clears_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && !rx_start) |=> !busy);
endmodule

// File: rtl/rx_disable_latch.sv
module rx_disable_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic char_valid,
  input  logic disable_req,
  output logic disabled
);
  logic dis_q;
  logic boundary;

  // A boundary is any edge that is not inside a character.
  assign boundary = char_valid || !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dis_q <= 1'b0;
    else if (boundary) dis_q <= disable_req;
  end

  assign disabled = dis_q;

  assert_hold_midchar_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !char_valid) |=> $stable(disabled));
  assert_take_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy || char_valid) |=> (disabled == $past(disable_req)));
endmodule

// File: rtl/rx_char_classify.sv
module rx_char_classify
  import uart_rx_gate_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] char_data,
  input  logic [DATA_W-1:0] xon_char,
  input  logic [DATA_W-1:0] xoff_char,
  input  logic [DATA_W-1:0] special_char,
  output char_class_t       cls
);
  localparam int PAD = (DATA_W < 8) ? 8 - DATA_W : 0;

  generate
    if (DATA_W == 8) begin : g_byte
      assign cls = classify_char(char_data, xon_char, xoff_char, special_char);
    end else if (DATA_W < 8) begin : g_narrow
      assign cls = classify_char({{PAD{1'b0}}, char_data}, {{PAD{1'b0}}, xon_char},
                                 {{PAD{1'b0}}, xoff_char}, {{PAD{1'b0}}, special_char});
    end else begin : g_wide
      assign cls.is_xon     = (char_data == xon_char);
      assign cls.is_xoff    = (char_data == xoff_char);
      assign cls.is_special = (char_data == special_char) &&
                              (char_data != xon_char) && (char_data != xoff_char);
    end
  endgenerate
endmodule

// File: rtl/uart_rx_gate.sv
module uart_rx_gate
  import uart_rx_gate_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              disable_req,
  input  logic              store_flow,
  input  logic [DATA_W-1:0] xon_char,
  input  logic [DATA_W-1:0] xoff_char,
  input  logic [DATA_W-1:0] special_char,
  input  logic              rx_start,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_data,
  output logic              xon_hit,
  output logic              xoff_hit,
  output logic              special_hit,
  output logic              rx_disabled
);
  logic        busy;
  logic        dis_eff;
  char_class_t cls;
  logic        ev_store;
  logic        ev_flow;

  rx_activity_track u_track (
    .clk(clk), .rst_n(rst_n), .rx_start(rx_start),
    .char_valid(char_valid), .busy(busy)
  );

  rx_disable_latch u_dis (
    .clk(clk), .rst_n(rst_n), .busy(busy), .char_valid(char_valid),
    .disable_req(disable_req), .disabled(dis_eff)
  );

  rx_char_classify #(.DATA_W(DATA_W)) u_cls (
    .char_data(char_data), .xon_char(xon_char), .xoff_char(xoff_char),
    .special_char(special_char), .cls(cls)
  );

  assign ev_flow  = cls.is_xon || cls.is_xoff;
  assign ev_store = store_decision(dis_eff, store_flow, cls);

  assign fifo_wr     = char_valid && ev_store;
  assign fifo_data   = char_data;
  assign xon_hit     = char_valid && cls.is_xon;
  assign xoff_hit    = char_valid && cls.is_xoff;
  assign special_hit = char_valid && !dis_eff && cls.is_special;
  assign rx_disabled = dis_eff;

  assert_no_write_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_disabled |-> !fifo_wr);
  assert_no_special_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_disabled |-> !special_hit);
  assert_quiet_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !char_valid |-> !(fifo_wr || xon_hit || xoff_hit || special_hit));
  assert_flow_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_flow && !store_flow) |-> !fifo_wr);
  assert_xon_on_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (char_valid && rx_disabled && char_data == xon_char) |-> xon_hit);
  assert_special_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    special_hit |-> !(xon_hit || xoff_hit));
endmodule

// File: tb/uart_rx_gate_test.sv
`timescale 1ns/1ps
module uart_rx_gate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disable_req = 1'b0, store_flow = 1'b0;
  logic [7:0] xon_char = 8'h11, xoff_char = 8'h13, special_char = 8'h7E;
  logic       rx_start = 1'b0, char_valid = 1'b0;
  logic [7:0] char_data = 8'h00;
  logic       fifo_wr, xon_hit, xoff_hit, special_hit, rx_disabled;
  logic [7:0] fifo_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  uart_rx_gate #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .disable_req(disable_req), .store_flow(store_flow),
    .xon_char(xon_char), .xoff_char(xoff_char), .special_char(special_char),
    .rx_start(rx_start), .char_valid(char_valid), .char_data(char_data),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .xon_hit(xon_hit), .xoff_hit(xoff_hit),
    .special_hit(special_hit), .rx_disabled(rx_disabled)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive right after a falling edge; sample 1 ns later, before the rising edge.
  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle_disable(input logic d);
    step(); disable_req = d;
    step(); step();
    #1;
    check(rx_disabled == d, "R4 idle follow", rx_disabled, d);
  endtask

  task automatic send_and_check(input logic [7:0] d, input logic dis);
    logic is_flow, exp_wr, exp_sp, exp_on, exp_off;
    step();
    char_valid = 1'b1; char_data = d;
    #1;
    exp_on  = (d == xon_char);
    exp_off = (d == xoff_char);
    is_flow = exp_on | exp_off;
    exp_wr  = !dis && (!is_flow || store_flow);
    exp_sp  = !dis && (d == special_char) && !is_flow;
    if (!is_flow) begin
      if (dis) check(fifo_wr == 1'b0, "R3 drop", fifo_wr, 0);
      else     check(fifo_wr == 1'b1 && fifo_data == d, "R2 store", {fifo_wr, fifo_data}, {1'b1, d});
    end else begin
      check(fifo_wr == exp_wr, "R8 flow store", fifo_wr, exp_wr);
    end
    check(xon_hit == exp_on && xoff_hit == exp_off, "R6 flow detect",
          {xon_hit, xoff_hit}, {exp_on, exp_off});
    check(special_hit == exp_sp, "R7 special", special_hit, exp_sp);
    step();
    char_valid = 1'b0;
    #1;
    check(!(fifo_wr | xon_hit | xoff_hit | special_hit), "R9 quiet",
          {fifo_wr, xon_hit, xoff_hit, special_hit}, 0);
  endtask

  task automatic sweep();
    for (int dis = 0; dis < 2; dis++) begin
      for (int sf = 0; sf < 2; sf++) begin
        store_flow = sf[0];
        settle_disable(dis[0]);
        for (int v = 0; v < 256; v++) send_and_check(v[7:0], dis[0]);
      end
    end
  endtask

  task automatic midchar(input logic from, input logic to);
    settle_disable(from);
    step(); rx_start = 1'b1;
    step(); rx_start = 1'b0; disable_req = to;
    for (int i = 0; i < 4; i++) begin
      step(); #1;
      check(rx_disabled == from, "R5 held mid-char", rx_disabled, from);
    end
    step(); char_valid = 1'b1; char_data = 8'h41; #1;
    check(fifo_wr == !from, "R5 old setting gates char", fifo_wr, !from);
    check(rx_disabled == from, "R5 held at strobe", rx_disabled, from);
    step(); char_valid = 1'b0; #1;
    check(rx_disabled == to, "R5 taken after strobe", rx_disabled, to);
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    check(rx_disabled == 1'b0 && !fifo_wr && !xon_hit && !xoff_hit && !special_hit,
          "R1 reset", {rx_disabled, fifo_wr, xon_hit, xoff_hit, special_hit}, 0);
    step(); step();
    rst_n = 1'b1;
    #1;
    check(rx_disabled == 1'b0, "R1 after release", rx_disabled, 0);
    sweep();
    xon_char = 8'hA5; xoff_char = 8'h5A; special_char = 8'h5A;
    sweep();
    xon_char = 8'h11; xoff_char = 8'h13; special_char = 8'h7E; store_flow = 1'b0;
    midchar(1'b0, 1'b1);
    midchar(1'b1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule